// File: doc/BRIEF.md
# Double-Buffered Multi-Channel PWM Generator

This block turns an 8-bit compare value into a fast pulse-width modulated output. One free-running timer, advanced once every `PRESC_DIV` clocks, is shared by every channel; each channel compares the timer against its own active threshold and drives its pin low below that threshold and high at or above it. The period is therefore 2^`RES_W` timer ticks for all channels, while each channel's duty is set on its own.

Software or a measuring block writes a new setting into a per-channel holding register through a strobe-qualified data port. The holding value reaches the active threshold only when the timer wraps from its maximum back to zero, so a period that is already under way is never cut short or stretched. In the default write mode the data on the port is a measured duty (for instance the high-time count of a slow 1 kHz input scaled to 256 steps), and the block converts it into the threshold that reproduces that same duty at the fast rate. With a 20 MHz clock and the default divide-by-2, the output runs near 39.06 kHz.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: After reset the timer is zero and both the holding and active thresholds of every channel are FFh, so each output stays low until the timer first reaches FFh.
- R2: The timer advances by one every `PRESC_DIV` clocks (default 2) and wraps from FFh to 00h, giving a period of 256 x `PRESC_DIV` clocks.
- R3: With the enable high, a channel output is low while the timer is below the active threshold and high while it is equal to or above it.
- R4: A write (strobe bit for that channel high, data in that channel's slice of `wr_data`) lands in the holding register only; the active threshold takes the holding value at the wrap from FFh to 00h and at no other time.
- R5: A write made on the same clock edge as a wrap is not used at that wrap; it becomes active at the next wrap.
- R6: In duty mode the stored threshold for a written duty d (9 bits) is 256 - d for d from 1 to 255, 00h for any d of 256 or more, and FFh for d equal to 0; the output is thus high for d ticks of each period (one tick when d is 0).
- R7: Threshold FFh yields one high tick per period, 80h yields 128 high ticks (50 %), and 00h yields a permanently high output.
- R8: With the enable low all outputs are low, while the timer keeps running, so outputs resume in phase when the enable returns.
- R9: All channels share the same timer and period, and a write to one channel does not alter any other channel's output.
- R10: When several writes reach a channel within one period, only the last one before the wrap becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Output enable; low forces all outputs low |
| wr_en | input | NUM_CH | Per-channel write strobe for the holding register |
| wr_data | input | NUM_CH x (RES_W+1) | Per-channel write data: measured duty (duty mode) or raw threshold |
| pwm_out | output | NUM_CH | PWM outputs, one per channel |

## Verification
The checker assumes the enable is held steady across the clock edges it reasons about when it ties a falling output to a wrap and a rising output to the timer meeting the threshold; these two properties are therefore qualified on the enable being high both before and after the edge. Reset is taken to be held for at least one clock so that the timer, prescaler and thresholds start from known values. The stimulus changes the enable and the write strobes only at falling clock edges and holds the enable constant through every measured period, while the bench model recomputes timer, thresholds and outputs on each rising edge and compares them with the pins shortly after each falling edge.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

   // Meaning of the data carried by the write port.
   typedef enum logic {
      WR_RAW  = 1'b0,   // data low bits are the threshold itself
      WR_DUTY = 1'b1    // data is a measured duty, converted to a threshold
   } wr_mode_e;

endpackage

// File: rtl/pwm_tick_gen.sv
// Shared timebase: prescaler plus wrapping period counter.
module pwm_tick_gen #(
   parameter int RES_W     = 8,
   parameter int PRESC_DIV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [RES_W-1:0] cnt_o,
   output logic             tick_o,
   output logic             wrap_o
);
   localparam logic [RES_W-1:0] CNT_MAX = '1;

   logic [RES_W-1:0] cnt_q;

   generate
      if (PRESC_DIV == 1) begin : g_nodiv
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(PRESC_DIV);
         localparam logic [PW-1:0] PC_LAST = PW'(PRESC_DIV - 1);
         logic [PW-1:0] pc_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pc_q <= '0;
            end else if (pc_q == PC_LAST) begin
               pc_q <= '0;
            end else begin
               pc_q <= pc_q + 1'b1;
            end
         end

         assign tick_o = (pc_q == PC_LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = tick_o && (cnt_q == CNT_MAX);

endmodule

// File: rtl/pwm_duty_map.sv
// Converts a measured duty (0 .. 2**RES_W and above) into a threshold.
module pwm_duty_map #(
   parameter int RES_W = 8
) (
   input  logic [RES_W:0]   duty_i,
   output logic [RES_W-1:0] cmp_o
);
   localparam logic [RES_W:0] FULL = {1'b1, {RES_W{1'b0}}};

   logic [RES_W:0] diff;

   assign diff = FULL - duty_i;

   always_comb begin
      if (duty_i[RES_W]) begin
         cmp_o = '0;              // saturate: always high
      end else if (duty_i == '0) begin
         cmp_o = '1;              // smallest achievable duty
      end else begin
         cmp_o = diff[RES_W-1:0];
      end
   end

endmodule

// File: rtl/pwm_cmp_chan.sv
// One channel: holding and active threshold, comparator, gated output.
module pwm_cmp_chan #(
   parameter int                   RES_W   = 8,
   parameter pwm_gen_pkg::wr_mode_e WR_MODE = pwm_gen_pkg::WR_DUTY,
   parameter logic [RES_W-1:0]     RST_CMP = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wrap,
   input  logic [RES_W-1:0] cnt,
   input  logic             wr,
   input  logic [RES_W:0]   wdata,
   output logic [RES_W-1:0] shd_o,
   output logic [RES_W-1:0] act_o,
   output logic             pwm_o
);
   logic [RES_W-1:0] wcmp;
   logic [RES_W-1:0] shd_q;
   logic [RES_W-1:0] act_q;

   generate
      if (WR_MODE == pwm_gen_pkg::WR_DUTY) begin : g_map
         pwm_duty_map #(.RES_W(RES_W)) u_map (
            .duty_i (wdata),
            .cmp_o  (wcmp)
         );
      end else begin : g_raw
         assign wcmp = wdata[RES_W-1:0];
      end
   endgenerate

   // Holding register follows writes.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shd_q <= RST_CMP;
      end else if (wr) begin
         shd_q <= wcmp;
      end
   end

   // Active register takes the pre-edge holding value only on wrap.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= RST_CMP;
      end else if (wrap) begin
         act_q <= shd_q;
      end
   end

   assign shd_o = shd_q;
   assign act_o = act_q;
   assign pwm_o = en && (cnt >= act_q);

endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen #(
   parameter int                   RES_W     = 8,
   parameter int                   PRESC_DIV = 2,
   parameter int                   NUM_CH    = 2,
   parameter pwm_gen_pkg::wr_mode_e WR_MODE   = pwm_gen_pkg::WR_DUTY
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en,
   input  logic [NUM_CH-1:0]           wr_en,
   input  logic [NUM_CH*(RES_W+1)-1:0] wr_data,
   output logic [NUM_CH-1:0]           pwm_out
);
   localparam int DIN_W = RES_W + 1;
   localparam logic [RES_W-1:0] RST_CMP = '1;

   // Elaboration-time parameter checks.
   generate
      if (RES_W < 2 || RES_W > 16) begin : g_bad_res
         $error("pwm_dbuf_gen: RES_W must be 2..16");
      end
      if (PRESC_DIV < 1) begin : g_bad_div
         $error("pwm_dbuf_gen: PRESC_DIV must be at least 1");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("pwm_dbuf_gen: NUM_CH must be at least 1");
      end
   endgenerate

   logic [RES_W-1:0]        cnt_q;
   logic                    tick;
   logic                    wrap;
   logic [NUM_CH*RES_W-1:0] shd_vec;
   logic [NUM_CH*RES_W-1:0] act_vec;

   pwm_tick_gen #(
      .RES_W     (RES_W),
      .PRESC_DIV (PRESC_DIV)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_o  (cnt_q),
      .tick_o (tick),
      .wrap_o (wrap)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         pwm_cmp_chan #(
            .RES_W   (RES_W),
            .WR_MODE (WR_MODE),
            .RST_CMP (RST_CMP)
         ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .wrap  (wrap),
            .cnt   (cnt_q),
            .wr    (wr_en[c]),
            .wdata (wr_data[c*DIN_W +: DIN_W]),
            .shd_o (shd_vec[c*RES_W +: RES_W]),
            .act_o (act_vec[c*RES_W +: RES_W]),
            .pwm_o (pwm_out[c])
         );
      end
   endgenerate

endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk #(
   parameter int RES_W  = 8,
   parameter int NUM_CH = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    en,
   input logic [RES_W-1:0]        cnt,
   input logic                    tick,
   input logic                    wrap,
   input logic [NUM_CH*RES_W-1:0] shd,
   input logic [NUM_CH*RES_W-1:0] act,
   input logic [NUM_CH-1:0]       pwm
);
   // R2: timer steps by one after each tick, holds otherwise
   assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && tick) |-> (cnt == $past(cnt) + 1'b1));
   assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !tick) |-> $stable(cnt));

   // R4: active thresholds move only on a wrap
   assert_act_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !wrap) |-> $stable(act));
   // R5: on a wrap the active value is the holding value from before the edge
   assert_act_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && wrap) |-> (act == $past(shd)));

   // R8: disabled outputs stay low
   assert_pwm_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (pwm == '0));

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         // R3: a falling output can only follow a wrap
         assert_pwm_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(pwm[i]) && $past(en) && en) |-> $past(wrap));
         // R3: a rising output means the timer has just met the threshold
         assert_pwm_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(pwm[i]) && $past(en) && en) |-> (cnt == act[i*RES_W +: RES_W]));
      end
   endgenerate

endmodule

bind pwm_dbuf_gen pwm_dbuf_chk #(
   .RES_W  (RES_W),
   .NUM_CH (NUM_CH)
) u_pwm_dbuf_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .en    (en),
   .cnt   (cnt_q),
   .tick  (tick),
   .wrap  (wrap),
   .shd   (shd_vec),
   .act   (act_vec),
   .pwm   (pwm_out)
);

// File: tb/pwm_dbuf_gen_bench.sv
`timescale 1ns/1ps
module pwm_dbuf_gen_bench;
   localparam int NCH   = 2;
   localparam int DW    = 9;
   localparam int DIV   = 2;
   localparam int PER   = 256 * DIV;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [NCH-1:0]   wr_en = '0;
   logic [NCH*DW-1:0] wr_data = '0;
   logic [NCH-1:0]   pwm_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Behavioural reference state
   int m_cnt, m_pc;
   int m_act [NCH];
   int m_shd [NCH];

   always #2.5 clk = ~clk;

   pwm_dbuf_gen u_pwm_dbuf_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .pwm_out (pwm_out)
   );

   function automatic int duty_to_cmp(int d);
      if (d >= 256) return 0;
      if (d == 0)   return 255;
      return 256 - d;
   endfunction

   task automatic check(string req, int actual, int expected, string what);
      checks++;
      if (actual !== expected) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, actual, expected, $time);
      end
   endtask

   // Reference model, updated on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pc = 0;
         for (int c = 0; c < NCH; c++) begin m_act[c] = 255; m_shd[c] = 255; end
      end else begin
         bit tk, wp;
         tk = (m_pc == DIV - 1);
         wp = tk && (m_cnt == 255);
         for (int c = 0; c < NCH; c++) begin
            if (wp) m_act[c] = m_shd[c];
            if (wr_en[c]) m_shd[c] = duty_to_cmp(int'(wr_data[c*DW +: DW]));
         end
         m_pc = tk ? 0 : m_pc + 1;
         if (tk) m_cnt = (m_cnt + 1) % 256;
      end
   end

   // Per-cycle comparison, just after each falling edge (R3, R8)
   always @(negedge clk) begin
      #0.5;
      if (rst_n && !done) begin
         for (int c = 0; c < NCH; c++) begin
            int exp_v;
            exp_v = (en && (m_cnt >= m_act[c])) ? 1 : 0;
            check("R3", int'(pwm_out[c]), exp_v, $sformatf("cycle model ch%0d", c));
         end
      end
   end

   task automatic write_ch(int c, int d);
      wr_en[c] = 1'b1;
      wr_data[c*DW +: DW] = DW'(d);
      @(negedge clk);
      wr_en[c] = 1'b0;
   endtask

   // Advance to the first falling edge where a new period has begun
   task automatic sync_period();
      @(negedge clk);
      while (!(m_cnt == 0 && m_pc == 0)) @(negedge clk);
   endtask

   // Count high clocks per channel over one full period
   task automatic count_period(output int hi [NCH]);
      for (int c = 0; c < NCH; c++) hi[c] = 0;
      for (int k = 0; k < PER; k++) begin
         #0.5;
         for (int c = 0; c < NCH; c++) if (pwm_out[c]) hi[c]++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      int hi [NCH];
      repeat (4) @(negedge clk);
      #0.5;
      // R1: outputs low during reset
      check("R1", int'(pwm_out), 0, "pwm during reset");
      rst_n = 1'b1;
      en = 1'b1;
      @(negedge clk); #0.5;
      check("R1", int'(pwm_out), 0, "pwm just after reset");

      // R1/R7: reset threshold FFh gives one high tick per period
      sync_period();
      count_period(hi);
      check("R1", hi[0], DIV, "reset threshold high clocks ch0");
      check("R7", hi[1], DIV, "FFh high clocks ch1");

      // R6/R7/R9: 50 % on ch0, duty 64 on ch1
      write_ch(0, 128);
      write_ch(1, 64);
      sync_period(); sync_period();
      count_period(hi);
      check("R7", hi[0], 128 * DIV, "80h half duty ch0");
      check("R9", hi[1], 64 * DIV, "independent duty ch1");

      // R6: saturation and zero duty
      write_ch(0, 300);
      write_ch(1, 0);
      sync_period(); sync_period();
      count_period(hi);
      check("R6", hi[0], PER, "duty>=256 always high ch0");
      check("R6", hi[1], DIV, "duty 0 -> FFh ch1");

      // R6: duty 255, R2: period length via one-tick window at FFh
      write_ch(0, 255);
      write_ch(1, 1);
      sync_period(); sync_period();
      count_period(hi);
      check("R6", hi[0], 255 * DIV, "duty 255 ch0");
      check("R2", hi[1], DIV, "duty 1 single tick ch1");

      // R4: mid-period write does not disturb current period
      write_ch(1, 64);
      sync_period(); sync_period();
      repeat (100) @(negedge clk);
      write_ch(1, 200);
      // still in the period whose threshold came from duty 64
      #0.5;
      check("R4", int'(pwm_out[1]), 0, "ch1 before threshold after mid write");
      sync_period();
      count_period(hi);
      check("R4", hi[1], 200 * DIV, "mid-period write used at next wrap");

      // R10: last of several writes wins
      write_ch(0, 32);
      write_ch(0, 96);
      write_ch(0, 192);
      sync_period(); sync_period();
      count_period(hi);
      check("R10", hi[0], 192 * DIV, "last write wins ch0");

      // R5: write landing on the wrap edge is deferred one period
      write_ch(1, 64);
      sync_period(); sync_period();
      @(negedge clk);
      while (!(m_pc == DIV - 1 && m_cnt == 255)) @(negedge clk);
      write_ch(1, 160);   // strobe seen on the wrap edge
      count_period(hi);
      check("R5", hi[1], 64 * DIV, "same-edge write not used this period");
      count_period(hi);
      check("R5", hi[1], 160 * DIV, "same-edge write used next period");

      // R8: enable low forces output low, timer keeps phase
      write_ch(0, 300);
      sync_period(); sync_period();
      en = 1'b0;
      count_period(hi);
      check("R8", hi[0], 0, "disabled output ch0");
      check("R8", hi[1], 0, "disabled output ch1");
      repeat (37) @(negedge clk);
      en = 1'b1;
      #0.5;
      check("R8", int'(pwm_out[0]), 1, "re-enabled saturated ch0");
      sync_period();
      count_period(hi);
      check("R8", hi[1], 160 * DIV, "phase kept after re-enable ch1");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule